// File: doc/BRIEF.md
# Single-to-Half Precision Float Narrowing Converter

This block narrows a 32-bit binary floating-point word to a 16-bit binary floating-point word. A two-bit selector picks one of four rounding directions. A separate truncation control overrides the selector and always rounds toward zero, which suits integer-style rounding sequences. Special values are mapped directly. Inputs whose magnitude is far below the smallest half-precision step collapse to a signed zero. Single-precision subnormal inputs are flushed to zero. Results that fall below the half-precision normal range are emitted as half-precision subnormals.

The conversion is purely combinational. A parameter places a register on the output, giving one cycle of latency. With the register removed, the result is available in the same cycle. Nothing else is stored, so every result depends only on the word, selector and control presented one cycle earlier (or in the same cycle when unregistered).

Top module: `fp32_to_fp16_cvt`

## Requirements
- R1: Any input with exponent field 8'hFF and a nonzero fraction yields 16'h7FFF, whatever its sign and rounding controls.
- R2: An input with exponent field 8'hFF and a zero fraction yields an infinity of the same sign: 16'h7C00 when positive, 16'hFC00 when negative.
- R3: An input whose biased exponent field is 8'h5D or below yields a zero with the input's sign (16'h0000 or 16'h8000) under every rounding setting. This range includes zeros and single-precision subnormals.
- R4: For normal-range results, the exponent is rebiased by subtracting 112. The 23-bit fraction is reduced to 10 bits by dropping 13 bits with rounding. In nearest mode a value exactly halfway between two results goes to the one with an even last bit.
- R5: rnd_sel encodes 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward minus infinity and 2'b11 toward plus infinity. The two infinity-directed modes round the magnitude up or down according to the input sign.
- R6: While chop_int is 1, every finite result is rounded toward zero whatever rnd_sel holds. A finite input then never becomes an infinity.
- R7: When the rebiased exponent is 0 or negative, the fraction is shifted right by an extra (1 - exponent) positions. The result is encoded as a half-precision subnormal (exponent field 0) and rounded in the selected direction.
- R8: Rounding a subnormal may carry into the implicit bit. The result is then the smallest normal number, with exponent field 1 and a zero fraction.
- R9: Rounding may carry out of a normal fraction. The exponent then rises by one and the fraction becomes zero.
- R10: A result whose exponent exceeds the largest finite exponent becomes a signed infinity under nearest-even and when rounding away from zero. When the effective direction is toward zero for that sign, the result is instead the signed largest finite value, 16'h7BFF or 16'hFBFF.
- R11: With OUT_REG = 1, hp_out shows the conversion of the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears hp_out to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| sp_in | input | 32 | Single-precision operand |
| rnd_sel | input | 2 | Rounding direction selector |
| chop_int | input | 1 | Forces round-toward-zero when set |
| hp_out | output | 16 | Half-precision result |

## Verification
On every cycle, assertions check the fixed mappings that depend on the input class alone:
- the NaN code,
- signed infinities,
- the flush-to-zero band,
- preservation of the sign,
- the absence of infinities under forced truncation,
- the one-cycle register transfer.

The bench's scenarios cover the behaviour that depends on arithmetic detail:
- ties to even,
- direction-by-sign rounding,
- the extra subnormal shift,
- carries into the implicit bit and into the exponent,
- the choice between infinity and the largest finite value on overflow.

For these, directed corner vectors and a behavioural reference run over thousands of random operands.

// File: rtl/fp16cvt_pkg.sv
package fp16cvt_pkg;

    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int SP_W       = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int HP_EXP_W   = 5;
    localparam int HP_FRAC_W  = 10;
    localparam int HP_W       = 1 + HP_EXP_W + HP_FRAC_W;

    localparam int SP_BIAS    = (1 << (SP_EXP_W - 1)) - 1;
    localparam int HP_BIAS    = (1 << (HP_EXP_W - 1)) - 1;
    localparam int BIAS_GAP   = SP_BIAS - HP_BIAS;
    localparam int SP_EXP_ALL = (1 << SP_EXP_W) - 1;
    localparam int HP_EXP_ALL = (1 << HP_EXP_W) - 1;

    // biased input exponents at or below this value collapse to signed zero
    localparam int FLUSH_EXP  = 93;

    localparam int SIG_W      = SP_FRAC_W + 1;
    localparam int FRAC_DROP  = SP_FRAC_W - HP_FRAC_W;
    // deepest right shift reachable by a value just above the flush band
    localparam int MAX_SHIFT  = FRAC_DROP + 1 - (FLUSH_EXP + 1 - BIAS_GAP);
    localparam int SHIFT_W    = $clog2(MAX_SHIFT + 1);
    localparam int EXP_CALC_W = SP_EXP_W + 2;
    localparam int MANT_W     = SIG_W + 1;
    localparam int WIDE_W     = SIG_W + MAX_SHIFT + 2;

    localparam logic [HP_W-2:0] HP_MAG_INF  = {{HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
    localparam logic [HP_W-2:0] HP_MAG_MAXF = {{(HP_EXP_W-1){1'b1}}, 1'b0, {HP_FRAC_W{1'b1}}};
    localparam logic [HP_W-1:0] HP_QNAN     = {1'b0, {(HP_W-1){1'b1}}};

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_NEG    = 2'b10,
        RM_TO_POS    = 2'b11
    } rnd_mode_e;

    // rounding direction applied to the magnitude
    typedef enum logic [1:0] {
        RD_EVEN = 2'b00,
        RD_CHOP = 2'b01,
        RD_AWAY = 2'b10
    } rnd_dir_e;

    typedef enum logic [1:0] {
        CLS_FINITE = 2'b00,
        CLS_TINY   = 2'b01,
        CLS_INF    = 2'b10,
        CLS_NAN    = 2'b11
    } in_class_e;

    typedef struct packed {
        logic                         sign;
        in_class_e                    cls;
        logic signed [EXP_CALC_W-1:0] hexp;
        logic [SIG_W-1:0]             sig;
        logic [SHIFT_W-1:0]           shamt;
    } unpacked_t;

    typedef struct packed {
        logic                         sign;
        in_class_e                    cls;
        logic signed [EXP_CALC_W-1:0] hexp;
        logic [MANT_W-1:0]            mant;
        rnd_dir_e                     dir;
    } rounded_t;

    function automatic rnd_dir_e pick_dir(input rnd_mode_e mode, input logic sign,
                                          input logic chop_force);
        rnd_dir_e d;
        if (chop_force) begin
            d = RD_CHOP;
        end else begin
            case (mode)
                RM_NEAR_EVEN: d = RD_EVEN;
                RM_TO_ZERO:   d = RD_CHOP;
                RM_TO_NEG:    d = sign ? RD_AWAY : RD_CHOP;
                RM_TO_POS:    d = sign ? RD_CHOP : RD_AWAY;
                default:      d = RD_EVEN;
            endcase
        end
        return d;
    endfunction

    function automatic logic round_inc(input rnd_dir_e dir, input logic lsb,
                                       input logic guard, input logic sticky);
        logic inc;
        case (dir)
            RD_EVEN: inc = guard & (sticky | lsb);
            RD_AWAY: inc = guard | sticky;
            default: inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/fcv_unpack.sv
module fcv_unpack
    import fp16cvt_pkg::*;
(
    input  logic [SP_W-1:0] src,
    output unpacked_t       fields
);
    logic [SP_EXP_W-1:0]  bexp;
    logic [SP_FRAC_W-1:0] frac;
    int                   reb_i;
    int                   sh_i;

    assign bexp = src[SP_W-2 -: SP_EXP_W];
    assign frac = src[SP_FRAC_W-1:0];

    always_comb begin
        fields.sign = src[SP_W-1];
        fields.sig  = {1'b1, frac};

        if (int'(bexp) == SP_EXP_ALL) begin
            fields.cls = (frac != '0) ? CLS_NAN : CLS_INF;
        end else if (int'(bexp) <= FLUSH_EXP) begin
            fields.cls = CLS_TINY;
        end else begin
            fields.cls = CLS_FINITE;
        end

        // rebias; non-positive exponents widen the shift and pin the exponent at 1
        reb_i = int'(bexp) - BIAS_GAP;
        if (reb_i <= 0) begin
            sh_i        = FRAC_DROP + (1 - reb_i);
            fields.hexp = EXP_CALC_W'(1);
        end else begin
            sh_i        = FRAC_DROP;
            fields.hexp = EXP_CALC_W'(reb_i);
        end
        if (sh_i > MAX_SHIFT) begin
            sh_i = MAX_SHIFT;
        end
        fields.shamt = SHIFT_W'(sh_i);
    end
endmodule

// File: rtl/fcv_round.sv
module fcv_round
    import fp16cvt_pkg::*;
(
    input  unpacked_t fields,
    input  rnd_mode_e mode,
    input  logic      chop_force,
    output rounded_t  rnd
);
    logic [WIDE_W-1:0] wide;
    logic [SIG_W-1:0]  kept;
    logic              guard;
    logic              sticky;
    logic              inc;
    rnd_dir_e          dir;

    always_comb begin
        wide   = {fields.sig, {(MAX_SHIFT + 2){1'b0}}} >> fields.shamt;
        kept   = wide[WIDE_W-1 -: SIG_W];
        guard  = wide[MAX_SHIFT + 1];
        sticky = |wide[MAX_SHIFT:0];
        dir    = pick_dir(mode, fields.sign, chop_force);
        inc    = round_inc(dir, kept[0], guard, sticky);

        rnd.sign = fields.sign;
        rnd.cls  = fields.cls;
        rnd.hexp = fields.hexp;
        rnd.dir  = dir;
        rnd.mant = {1'b0, kept} + MANT_W'(inc);
    end
endmodule

// File: rtl/fcv_pack.sv
module fcv_pack
    import fp16cvt_pkg::*;
(
    input  rounded_t        rnd,
    output logic [HP_W-1:0] half
);
    int                   e_i;
    logic                 carry;
    logic [HP_FRAC_W-1:0] f_out;

    always_comb begin
        carry = |rnd.mant[MANT_W-1:HP_FRAC_W+1];
        e_i   = int'(rnd.hexp);
        f_out = rnd.mant[HP_FRAC_W-1:0];
        if (carry) begin
            e_i   = e_i + 1;
            f_out = '0;
        end else if (!rnd.mant[HP_FRAC_W]) begin
            e_i = 0;
        end

        case (rnd.cls)
            CLS_NAN:  half = HP_QNAN;
            CLS_INF:  half = {rnd.sign, HP_MAG_INF};
            CLS_TINY: half = {rnd.sign, {(HP_W-1){1'b0}}};
            default: begin
                if (e_i >= HP_EXP_ALL) begin
                    half = (rnd.dir == RD_CHOP) ? {rnd.sign, HP_MAG_MAXF}
                                                : {rnd.sign, HP_MAG_INF};
                end else begin
                    half = {rnd.sign, HP_EXP_W'(e_i), f_out};
                end
            end
        endcase
    end
endmodule

// File: rtl/fp32_to_fp16_cvt.sv
module fp32_to_fp16_cvt
    import fp16cvt_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] sp_in,
    input  logic [1:0]  rnd_sel,
    input  logic        chop_int,
    output logic [15:0] hp_out
);
    unpacked_t       fields;
    rounded_t        rnd;
    logic [HP_W-1:0] cvt_word;
    logic            in_nan;
    logic            in_inf;
    logic            in_tiny;

    fcv_unpack u_unpack (
        .src    (sp_in),
        .fields (fields)
    );

    fcv_round u_round (
        .fields     (fields),
        .mode       (rnd_mode_e'(rnd_sel)),
        .chop_force (chop_int),
        .rnd        (rnd)
    );

    fcv_pack u_pack (
        .rnd  (rnd),
        .half (cvt_word)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    hp_out <= '0;
                end else begin
                    hp_out <= cvt_word;
                end
            end

            // R11
            out_latency_chk: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> hp_out == $past(cvt_word));
        end else begin : g_comb
            assign hp_out = cvt_word;
        end
    endgenerate

    assign in_nan  = (sp_in[30:23] == 8'hFF) && (sp_in[22:0] != '0);
    assign in_inf  = (sp_in[30:23] == 8'hFF) && (sp_in[22:0] == '0);
    assign in_tiny = (sp_in[30:23] <= 8'h5D);

    // R1
    nan_code_chk: assert property (@(posedge clk) disable iff (rst)
        in_nan |-> cvt_word == 16'h7FFF);

    // R2
    inf_keep_sign_chk: assert property (@(posedge clk) disable iff (rst)
        in_inf |-> cvt_word == {sp_in[31], 15'h7C00});

    // R3
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_tiny |-> cvt_word == {sp_in[31], 15'h0000});

    // R4
    sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_nan |-> cvt_word[15] == sp_in[31]);

    // R6
    chop_finite_chk: assert property (@(posedge clk) disable iff (rst)
        (chop_int && !in_nan && !in_inf) |-> cvt_word[14:10] != 5'h1F);
endmodule

// File: tb/fp32_to_fp16_cvt_bench.sv
module fp32_to_fp16_cvt_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] sp_in = '0;
    logic [1:0]  rnd_sel = '0;
    logic        chop_int = 1'b0;
    logic [15:0] hp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    fp32_to_fp16_cvt #(.OUT_REG(1'b1)) u_fp32_to_fp16_cvt (
        .clk      (clk),
        .rst      (rst),
        .sp_in    (sp_in),
        .rnd_sel  (rnd_sel),
        .chop_int (chop_int),
        .hp_out   (hp_out)
    );

    // behavioural model: divide the significand by the step of the target grid
    function automatic logic [15:0] ref_cvt(input logic [31:0] x, input logic [1:0] md,
                                            input logic tr);
        int     ex, eh, k;
        longint m, dv, q, rm, hv, n;
        bit     s, chop, away, inc;
        s  = x[31];
        ex = int'(x[30:23]);
        if (ex == 255) return (x[22:0] != 0) ? 16'h7FFF : {s, 15'h7C00};
        if (ex <= 93) return {s, 15'h0000};
        chop = tr || md == 2'd1 || (md == 2'd2 && !s) || (md == 2'd3 && s);
        away = !chop && md != 2'd0;
        eh = ex - 127;
        if (eh < -14) eh = -14;
        k  = eh - 10 - (ex - 150);
        m  = longint'({1'b1, x[22:0]});
        dv = longint'(1) << k;
        q  = m / dv;
        rm = m % dv;
        hv = dv / 2;
        if (chop)      inc = 1'b0;
        else if (away) inc = (rm != 0);
        else           inc = (rm > hv) || (rm == hv && q[0]);
        n = q + longint'(inc);
        if (n == 2048) begin
            n  = 1024;
            eh = eh + 1;
        end
        if (eh > 15) return chop ? {s, 15'h7BFF} : {s, 15'h7C00};
        if (n < 1024) return {s, 5'd0, 10'(n)};
        return {s, 5'(eh + 15), 10'(n - 1024)};
    endfunction

    task automatic apply(input logic [31:0] x, input logic [1:0] md, input logic tr,
                         input logic [15:0] want, input string tag);
        logic [15:0] e;
        string       t;
        @(negedge clk);
        sp_in    = x;
        rnd_sel  = md;
        chop_int = tr;
        exp_q.push_back(want);
        tag_q.push_back(tag);
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (hp_out !== e) begin
            errors++;
            $display("FAIL %s in=%h mode=%0d chop=%0b actual=%h expected=%h",
                     t, x, md, tr, hp_out, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (hp_out !== 16'h0000) begin
            errors++;
            $display("FAIL R11 reset actual=%h expected=0000", hp_out);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1 NaN inputs
        apply(32'h7FC00000, 2'd0, 1'b0, 16'h7FFF, "R1");
        apply(32'hFF800001, 2'd3, 1'b1, 16'h7FFF, "R1");
        // R2 infinities
        apply(32'h7F800000, 2'd1, 1'b0, 16'h7C00, "R2");
        apply(32'hFF800000, 2'd0, 1'b0, 16'hFC00, "R2");
        // R3 flush band
        apply(32'h00000000, 2'd0, 1'b0, 16'h0000, "R3");
        apply(32'h80000001, 2'd2, 1'b0, 16'h8000, "R3");
        apply(32'h2E800000, 2'd3, 1'b0, 16'h0000, "R3");
        apply(32'hAE800000, 2'd2, 1'b0, 16'h8000, "R3");
        // R4 normal range and ties to even
        apply(32'h3F800000, 2'd0, 1'b0, 16'h3C00, "R4");
        apply(32'h40490FDB, 2'd0, 1'b0, 16'h4248, "R4");
        apply(32'h3F801000, 2'd0, 1'b0, 16'h3C00, "R4");
        apply(32'h3F803000, 2'd0, 1'b0, 16'h3C02, "R4");
        // R5 directed modes by sign
        apply(32'h3F801000, 2'd3, 1'b0, 16'h3C01, "R5");
        apply(32'h3F801000, 2'd2, 1'b0, 16'h3C00, "R5");
        apply(32'hBF801000, 2'd2, 1'b0, 16'hBC01, "R5");
        apply(32'hBF801000, 2'd3, 1'b0, 16'hBC00, "R5");
        apply(32'hBF801000, 2'd1, 1'b0, 16'hBC00, "R5");
        // R6 forced truncation
        apply(32'h3F801000, 2'd3, 1'b1, 16'h3C00, "R6");
        apply(32'h7F7FFFFF, 2'd3, 1'b1, 16'h7BFF, "R6");
        // R7 subnormal results
        apply(32'h33800000, 2'd0, 1'b0, 16'h0001, "R7");
        apply(32'h33000000, 2'd0, 1'b0, 16'h0000, "R7");
        apply(32'h33000000, 2'd3, 1'b0, 16'h0001, "R7");
        apply(32'h2F000000, 2'd3, 1'b0, 16'h0001, "R7");
        apply(32'h2F000000, 2'd0, 1'b0, 16'h0000, "R7");
        // R8 subnormal carry into implicit bit
        apply(32'h387FFFFF, 2'd0, 1'b0, 16'h0400, "R8");
        // R9 fraction carry into exponent
        apply(32'h3FFFFFFF, 2'd0, 1'b0, 16'h4000, "R9");
        // R10 overflow
        apply(32'h477FE000, 2'd0, 1'b0, 16'h7BFF, "R10");
        apply(32'h477FF000, 2'd0, 1'b0, 16'h7C00, "R10");
        apply(32'h7F7FFFFF, 2'd1, 1'b0, 16'h7BFF, "R10");
        apply(32'hFF7FFFFF, 2'd2, 1'b0, 16'hFC00, "R10");
        apply(32'hFF7FFFFF, 2'd3, 1'b0, 16'hFBFF, "R10");

        // random operands against the behavioural model (R4 R5 R6 R7 R10)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] x;
            logic [1:0]  md;
            logic        tr;
            x = $urandom;
            if (i % 2 == 1) x[30:23] = 8'(80 + $urandom_range(0, 70));
            md = 2'($urandom_range(0, 3));
            tr = ($urandom_range(0, 7) == 0);
            apply(x, md, tr, ref_cvt(x, md, tr), "R4 R5 R6 R7 R10 random");
        end

        // R11 synchronous reset clears the register
        @(negedge clk);
        sp_in = 32'h3F800000;
        rst   = 1'b1;
        @(negedge clk);
        checks++;
        if (hp_out !== 16'h0000) begin
            errors++;
            $display("FAIL R11 reset actual=%h expected=0000", hp_out);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule